// File: doc/BRIEF.md
# SPI Receive Descriptor Ring Engine

This block takes bytes delivered by an SPI receiver and stores them into memory buffers described by a ring of buffer descriptors. The descriptors live in a 16-bit word-addressed descriptor RAM. Each descriptor takes four words. Word 0 is the status/control word and word 1 is the byte count. Words 2 and 3 hold the high and low halves of a 32-bit buffer pointer. The engine fetches a descriptor and checks that it owns it. It then writes incoming bytes to consecutive buffer addresses. The buffer is closed when it is full or when a frame ends. On close the engine writes back the byte count and an updated status word, then moves to the next descriptor.

Ownership is handed over through the empty flag in the status word. The last descriptor carries a wrap flag that sends the engine back to the ring base, so the position of that flag alone sets the ring length. In master mode a continuous-mode flag keeps the descriptor owned after close, so the same buffer is refilled on every pass with no host action. Two event flags are kept: buffer-done and busy. The host clears them by writing ones, and an interrupt line is raised when a set flag is unmasked.

Top module: `spi_rx_ring`

## Requirements
- R1: Descriptor at word address d: status at d, count at d+1, pointer high at d+2, pointer low at d+3. The n-th byte (from 0) of a buffer is written to pointer+n on the buffer write port.
- R2: If the fetched status has bit 15 (empty) at 0, arriving bytes are dropped. No buffer write happens, the descriptor is left unchanged, and event bit 1 (busy) is set. The engine keeps re-reading that descriptor until bit 15 is 1.
- R3: When the byte count reaches max_len_i, the buffer closes. The count word receives max_len_i, bit 11 (last) is written 0 if no frame-end is pending, and bit 15 is cleared.
- R4: A frame_end_i pulse closes the buffer after any byte already received has been stored. Bit 11 is written 1 and the count word receives the number of bytes stored.
- R5: After a descriptor whose bit 13 (wrap) is 1, the next descriptor is at ring_base_i. Otherwise it is at d+4.
- R6: Closing a descriptor whose bit 12 (interrupt) is 1 sets event bit 0 (buffer done). irq_o is 1 exactly when some event bit and its irq_mask_i bit are both 1.
- R7: If bit 9 (continuous) is 1 and master_i is 1, bit 15 stays 1 after close. In slave mode (master_i 0), bit 9 is ignored and bit 15 is cleared.
- R8: A byte that arrives while the previous byte is still unstored is discarded and marks overrun. The next close writes bit 1 (overrun) as 1 and clears bit 15 even under continuous mode.
- R9: On close, status bits 14, 10, 9, 8..2 and 0 and bits 13 and 12 are written back exactly as they were fetched.
- R10: Writing 1 to a bit of evt_clr_i clears that event bit on the next edge. A set in the same cycle wins over the clear.
- R11: After reset, evt_o and irq_o are 0 and no buffer or descriptor write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = SPI master mode, 0 = slave |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| frame_end_i | input | 1 | Frame-end strobe |
| ring_base_i | input | AW | Word address of the first descriptor |
| max_len_i | input | 16 | Buffer capacity in bytes |
| mem_req_o | output | 1 | Descriptor RAM access request |
| mem_we_o | output | 1 | Descriptor RAM write enable |
| mem_addr_o | output | AW | Descriptor RAM word address |
| mem_wdata_o | output | 16 | Descriptor RAM write data |
| mem_rdata_i | input | 16 | Descriptor RAM read data, one cycle after the request |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_addr_o | output | 32 | Buffer byte address |
| buf_data_o | output | 8 | Buffer byte data |
| evt_clr_i | input | 2 | Write-one-to-clear for event bits |
| irq_mask_i | input | 2 | Interrupt enable per event bit |
| evt_o | output | 2 | Event bits: 0 buffer done, 1 busy |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is overrun, because bytes are stored in the cycle after they arrive whenever a descriptor is open. A byte can only be left waiting during the six cycles spent closing one descriptor and fetching the next. The stimulus sends a frame-end and waits two cycles. It then sends three bytes back to back, which land in that window on a continuous-mode descriptor. This shows the overrun flag, the single stored byte, and the abort that clears ownership despite continuous mode. The busy path is reached by letting the ring wrap onto a descriptor the host has not returned.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int unsigned ST_E  = 15;
  localparam int unsigned ST_W  = 13;
  localparam int unsigned ST_I  = 12;
  localparam int unsigned ST_L  = 11;
  localparam int unsigned ST_CM = 9;
  localparam int unsigned ST_OV = 1;
  localparam int unsigned EV_RXB = 0;
  localparam int unsigned EV_BSY = 1;
  localparam int unsigned EV_W   = 2;
  localparam int unsigned DW     = 16;
  localparam int unsigned PW     = 32;

  typedef enum logic [2:0] {
    S_INIT, S_F_ST, S_F_PH, S_F_PL, S_F_CAP, S_RUN, S_C_LEN, S_C_ST
  } ctl_state_e;
endpackage

// File: rtl/spi_rx_byte_stage.sv
module spi_rx_byte_stage (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       frame_end_i,
  input  logic       take_i,
  input  logic       drop_i,
  input  logic       fe_clr_i,
  input  logic       ovr_clr_i,
  output logic       pend_v_o,
  output logic [7:0] pend_o,
  output logic       fe_o,
  output logic       ovr_o
);
  logic ovr_set;
  assign ovr_set = byte_valid_i && pend_v_o && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o <= 1'b0;
      pend_o   <= '0;
      fe_o     <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      if (byte_valid_i && (!pend_v_o || take_i)) begin
        pend_v_o <= 1'b1;
        pend_o   <= byte_i;
      end else if (take_i || drop_i) begin
        pend_v_o <= 1'b0;
      end
      fe_o  <= frame_end_i || (fe_o && !(fe_clr_i || drop_i));
      ovr_o <= ovr_set || (ovr_o && !ovr_clr_i);
    end
  end

  // R8
  ovr_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && pend_v_o && !take_i) |=> ovr_o);
endmodule

// File: rtl/spi_rx_evt.sv
module spi_rx_evt
  import spi_rx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] set_i,
  input  logic [EV_W-1:0] clr_i,
  input  logic [EV_W-1:0] mask_i,
  output logic [EV_W-1:0] evt_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= '0;
    else         evt_o <= set_i | (evt_o & ~clr_i);
  end

  assign irq_o = |(evt_o & mask_i);

  for (genvar b = 0; b < EV_W; b++) begin : g_chk
    // R10
    evt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_o[b]) |-> $past(set_i[b]));
  end

  // R6
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o == '0) |-> !irq_o);
endmodule

// File: rtl/spi_rx_ring_ctl.sv
module spi_rx_ring_ctl
  import spi_rx_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [DW-1:0] max_len_i,
  input  logic          pend_v_i,
  input  logic          fe_i,
  input  logic          ovr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          take_o,
  output logic          drop_o,
  output logic          fe_clr_o,
  output logic          ovr_clr_o,
  output logic          rxb_set_o,
  output logic          bsy_set_o,
  output logic [PW-1:0] buf_addr_o
);
  ctl_state_e    state_q, state_d;
  logic [AW-1:0] cur_q;
  logic [DW-1:0] st_q, cnt_q, st_new;
  logic [PW-1:0] ptr_q;
  logic          lfl_q, close_go;

  always_comb begin
    st_new        = st_q;
    st_new[ST_E]  = st_q[ST_CM] && master_i && !ovr_i;
    st_new[ST_L]  = lfl_q;
    st_new[ST_OV] = ovr_i;
  end

  always_comb begin
    state_d     = state_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    take_o      = 1'b0;
    drop_o      = 1'b0;
    fe_clr_o    = 1'b0;
    ovr_clr_o   = 1'b0;
    rxb_set_o   = 1'b0;
    close_go    = 1'b0;
    case (state_q)
      S_INIT: state_d = S_F_ST;
      S_F_ST: begin
        mem_req_o = 1'b1;
        state_d   = S_F_PH;
      end
      S_F_PH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(2);
        state_d    = S_F_PL;
      end
      S_F_PL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(3);
        state_d    = S_F_CAP;
      end
      S_F_CAP: begin
        if (st_q[ST_E]) state_d = S_RUN;
        else begin
          drop_o    = 1'b1;
          ovr_clr_o = 1'b1;
          state_d   = S_F_ST;
        end
      end
      S_RUN: begin
        take_o   = pend_v_i;
        close_go = (pend_v_i && (cnt_q + DW'(1) == max_len_i)) || (fe_i && !pend_v_i);
        if (close_go) begin
          fe_clr_o = 1'b1;
          state_d  = S_C_LEN;
        end
      end
      S_C_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(1);
        mem_wdata_o = cnt_q;
        state_d     = S_C_ST;
      end
      S_C_ST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = st_new;
        ovr_clr_o   = 1'b1;
        rxb_set_o   = st_q[ST_I];
        state_d     = S_F_ST;
      end
      default: state_d = S_INIT;
    endcase
  end

  assign bsy_set_o  = drop_o && pend_v_i;
  assign buf_addr_o = ptr_q + {{(PW-DW){1'b0}}, cnt_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_INIT;
      cur_q   <= '0;
      st_q    <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      lfl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_INIT:  cur_q <= ring_base_i;
        S_F_PH:  st_q <= mem_rdata_i;
        S_F_PL:  ptr_q[PW-1:DW] <= mem_rdata_i;
        S_F_CAP: begin
          ptr_q[DW-1:0] <= mem_rdata_i;
          cnt_q         <= '0;
        end
        S_RUN: begin
          if (take_o) cnt_q <= cnt_q + DW'(1);
          if (close_go) lfl_q <= fe_i;
        end
        S_C_ST:  cur_q <= st_q[ST_W] ? ring_base_i : cur_q + AW'(4);
        default: ;
      endcase
    end
  end

  // R2
  owned_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> st_q[ST_E]);
  // R1
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_o, mem_we_o}));
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && max_len_i != '0) |-> cnt_q < max_len_i);
  // R8
  ovr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == cur_q && ovr_i) |-> !mem_wdata_o[ST_E]);
endmodule

// File: rtl/spi_rx_ring.sv
module spi_rx_ring
  import spi_rx_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            master_i,
  input  logic            byte_valid_i,
  input  logic [7:0]      byte_i,
  input  logic            frame_end_i,
  input  logic [AW-1:0]   ring_base_i,
  input  logic [DW-1:0]   max_len_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            buf_we_o,
  output logic [PW-1:0]   buf_addr_o,
  output logic [7:0]      buf_data_o,
  input  logic [EV_W-1:0] evt_clr_i,
  input  logic [EV_W-1:0] irq_mask_i,
  output logic [EV_W-1:0] evt_o,
  output logic            irq_o
);
  logic pend_v, fe, ovr, take, drop, fe_clr, ovr_clr, rxb_set, bsy_set;
  logic [EV_W-1:0] evt_set;

  spi_rx_byte_stage u_stage (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .frame_end_i,
    .take_i(take), .drop_i(drop), .fe_clr_i(fe_clr), .ovr_clr_i(ovr_clr),
    .pend_v_o(pend_v), .pend_o(buf_data_o), .fe_o(fe), .ovr_o(ovr)
  );

  spi_rx_ring_ctl #(.AW(AW)) u_ctl (
    .clk_i, .rst_ni, .master_i, .ring_base_i, .max_len_i,
    .pend_v_i(pend_v), .fe_i(fe), .ovr_i(ovr),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .take_o(take), .drop_o(drop), .fe_clr_o(fe_clr), .ovr_clr_o(ovr_clr),
    .rxb_set_o(rxb_set), .bsy_set_o(bsy_set), .buf_addr_o
  );

  always_comb begin
    evt_set         = '0;
    evt_set[EV_RXB] = rxb_set;
    evt_set[EV_BSY] = bsy_set;
  end

  spi_rx_evt u_evt (
    .clk_i, .rst_ni, .set_i(evt_set), .clr_i(evt_clr_i), .mask_i(irq_mask_i),
    .evt_o, .irq_o
  );

  assign buf_we_o = take;

  // R11
  quiet_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !buf_we_o && !mem_we_o);
endmodule

// File: tb/spi_rx_ring_tb_top.sv
module spi_rx_ring_tb_top;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, bv = 1'b0, fe = 1'b0;
  logic [7:0] bdat = '0;
  logic [AW-1:0] base = 6'd8;
  logic [15:0] maxl = 16'd4;
  logic mreq, mwe, bwe, irq;
  logic [AW-1:0] maddr;
  logic [15:0] mwd, mrd;
  logic [31:0] baddr;
  logic [7:0] bout;
  logic [1:0] eclr = '0, emask = 2'b01, evt;
  logic [15:0] dram [0:63];
  logic [7:0]  bmem [0:1023];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_rx_ring #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .byte_valid_i(bv),
    .byte_i(bdat), .frame_end_i(fe), .ring_base_i(base), .max_len_i(maxl),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_rdata_i(mrd), .buf_we_o(bwe), .buf_addr_o(baddr), .buf_data_o(bout),
    .evt_clr_i(eclr), .irq_mask_i(emask), .evt_o(evt), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (mreq) begin
      if (mwe) dram[maddr] <= mwd;
      else     mrd <= dram[maddr];
    end
    if (bwe) bmem[baddr[9:0]] <= bout;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); bv = 1'b1; bdat = b;
    @(negedge clk); bv = 1'b0;
    idle(2);
  endtask

  task automatic frame_end();
    @(negedge clk); fe = 1'b1;
    @(negedge clk); fe = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) dram[i] = '0;
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    dram[8]  = 16'hD001; dram[10] = 16'h0000; dram[11] = 16'h0100;
    dram[12] = 16'h8000; dram[14] = 16'h0000; dram[15] = 16'h0200;
    dram[16] = 16'hA200; dram[18] = 16'h0000; dram[19] = 16'h0300;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 evt", 32'(evt), 0);
    chk("R11 irq", 32'(irq), 0);
    chk("R11 writes", 32'({bwe, mwe}), 0);
    idle(10);
    // full close, interrupt flag
    for (int i = 0; i < 4; i++) send_byte(8'h11 + 8'(i));
    idle(10);
    chk("R3 R9 status", 32'(dram[8]), 32'h5001);
    chk("R3 count", 32'(dram[9]), 4);
    for (int i = 0; i < 4; i++) chk("R1 data", 32'(bmem[256+i]), 32'(8'h11 + 8'(i)));
    chk("R6 rxb", 32'(evt), 32'b01);
    chk("R6 irq", 32'(irq), 1);
    @(negedge clk); eclr = 2'b01;
    @(negedge clk); eclr = 2'b00;
    chk("R10 clear", 32'(evt), 0);
    chk("R10 irq", 32'(irq), 0);
    // frame-end close
    send_byte(8'h21); send_byte(8'h22); frame_end();
    idle(10);
    chk("R4 status", 32'(dram[12]), 32'h0800);
    chk("R4 count", 32'(dram[13]), 2);
    chk("R1 data b", 32'({bmem[512], bmem[513]}), 32'h2122);
    chk("R6 no rxb", 32'(evt), 0);
    // continuous mode in master, wrap
    for (int i = 0; i < 4; i++) send_byte(8'h31 + 8'(i));
    idle(10);
    chk("R7 keep E", 32'(dram[16]), 32'hA200);
    chk("R7 count", 32'(dram[17]), 4);
    chk("R1 data c", 32'(bmem[771]), 32'h34);
    // wrapped onto non-owned descriptor
    send_byte(8'h55); idle(8); send_byte(8'h56);
    idle(10);
    chk("R2 bsy", 32'(evt), 32'b10);
    chk("R2 untouched", 32'(dram[8]), 32'h5001);
    chk("R2 no write", 32'(bmem[256]), 32'h11);
    chk("R6 masked", 32'(irq), 0);
    // return ownership; slave mode ignores CM
    @(negedge clk); dram[8] = 16'h8200; master = 1'b0; eclr = 2'b10;
    @(negedge clk); eclr = 2'b00;
    chk("R10 bsy clear", 32'(evt), 0);
    idle(12);
    for (int i = 0; i < 4; i++) send_byte(8'h61 + 8'(i));
    idle(10);
    chk("R7 slave", 32'(dram[8]), 32'h0200);
    chk("R5 wrap base", 32'(bmem[256]), 32'h61);
    // continuous descriptor then overrun
    @(negedge clk); dram[12] = 16'h8200; master = 1'b1;
    idle(12);
    send_byte(8'h71);
    frame_end();
    idle(2);
    @(negedge clk); bv = 1'b1; bdat = 8'h81;
    @(negedge clk); bdat = 8'h82;
    @(negedge clk); bdat = 8'h83;
    @(negedge clk); bv = 1'b0;
    idle(10);
    frame_end();
    idle(10);
    chk("R7 R4 cm close", 32'(dram[12]), 32'h8A00);
    chk("R5 next", 32'(dram[13]), 1);
    chk("R8 status", 32'(dram[16]), 32'h2A02);
    chk("R8 count", 32'(dram[17]), 1);
    chk("R8 stored", 32'({bmem[768], bmem[769]}), 32'h8132);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule